// File: doc/BRIEF.md
# Multi-Processor Device Interrupt Router

The router collects up to 64 level-style requests from peripheral sources into one shared request word and steers them to as many as four processors. Each processor owns a 64-bit enable mask. The block keeps, per processor, a routed word equal to the mask ANDed with the request word. It drives one level interrupt per processor that is high while any routed bit of that processor is set.

A source raises or drops its request by presenting a line number with a set/clear flag. Software programs the masks and reads back the request, mask and routed words through a simple 64-bit register port. Accesses of any other width, writes to read-only words and accesses to unmapped indices are flagged as errors. For every processor and line, the block emits a one-cycle post pulse when a routed bit goes from 0 to 1 and a clear pulse when it goes from 1 to 0. The cause can be either a source event or a mask write.

Top module: `dev_irq_router`

## Requirements
- R1: After reset every request, mask and routed bit is 0, every interrupt output is low and no event pulse, error or read-valid is active.
- R2: A source event with `src_valid`=1 sets request bit `src_line` when `src_set`=1 and clears it when `src_set`=0, visible from the next clock edge. Clearing a line whose request bit is already 0 changes no state and produces no event.
- R3: At every clock edge, each processor's routed word becomes its new mask ANDed with the new request word.
- R4: For processor c and line n, bit c*64+n of `post_evt` is high for exactly the one cycle after an edge where routed bit n of processor c went from 0 to 1. It is not raised when that routed bit was already 1, for example when an already-requested line is requested again.
- R5: For processor c and line n, bit c*64+n of `clr_evt` is high for exactly the one cycle after an edge where that routed bit went from 1 to 0. The cause may be a source clear or a mask write.
- R6: `irq_out[c]` is a register that equals the OR of processor c's routed word and changes on the same edge as that word.
- R7: The register index is `bus_addr[11:6]`; `bus_addr[5:0]` is ignored. Index 0 reads the request word, index 4+c reads the mask of processor c, and index 8+c reads the routed word of processor c. The value is the state before that edge's update. It is returned on `bus_rdata` with `bus_rvalid` one cycle after the request.
- R8: Only `bus_size`=3 (8 bytes) is accepted. Any other size raises `bus_err` for one cycle after the request and has no effect on any state.
- R9: A write to index 0 or 8..11, and any access to an index outside 0, 4..11, raises `bus_err` one cycle later and changes no state.
- R10: A mask write at index 4+c takes effect at the next edge. If a source event arrives in the same cycle, both take effect together, and the events reflect the combined change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 1 | Source event strobe |
| src_set | input | 1 | 1 = assert line, 0 = deassert line |
| src_line | input | 6 | Request line number |
| bus_req | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size, log2 bytes |
| bus_addr | input | 12 | Byte offset into register space |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| bus_err | output | 1 | Access error pulse |
| irq_out | output | 4 | Per-processor level interrupt |
| post_evt | output | 256 | Per-processor, per-line post pulses |
| clr_evt | output | 256 | Per-processor, per-line clear pulses |

## Verification
The bench repeats a request for a line that is already requested. A router that pulses on every source event rather than on routed edges would emit a second post. It also issues a clear for a line that is not requested, which an incorrect design would turn into a clear pulse or a state change. Mask writes that both drop and add routed bits check that clears come only from previously routed bits, and a mask write landing in the same cycle as a source event catches a design that lets one update overwrite the other. Narrow, read-only and unmapped accesses check that an erroneous write still leaves every mask untouched.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    localparam int MAX_CPU    = 4;
    localparam int IDX_LSB    = 6;
    localparam int REQ_IDX    = 0;
    localparam int MASK_BASE  = 4;
    localparam int ROUTE_BASE = MASK_BASE + MAX_CPU;
    localparam logic [1:0] SZ_64 = 2'b11;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_REQ   = 2'd1,
        SEL_MASK  = 2'd2,
        SEL_ROUTE = 2'd3
    } rd_sel_e;
endpackage

// File: rtl/irq_request_reg.sv
module irq_request_reg #(
    parameter int NLINES = 64,
    localparam int LW = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_valid,
    input  logic              src_set,
    input  logic [LW-1:0]     src_line,
    output logic [NLINES-1:0] req_d_o,
    output logic [NLINES-1:0] req_q_o
);
    typedef struct packed {
        logic [NLINES-1:0] req;
    } req_state_t;

    req_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (src_valid) begin
            st_d.req[src_line] = src_set;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_d_o = st_d.req;
    assign req_q_o = st_q.req;

    a_r2_line_set: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && src_set) |=> req_q_o[$past(src_line)]);

    a_r2_line_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && !src_set) |=> !req_q_o[$past(src_line)]);

    a_r2_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !src_valid |=> $stable(req_q_o));
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_router_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int AW   = 12,
    localparam int IW  = AW - IDX_LSB,
    localparam int CW  = $clog2(MAX_CPU)
) (
    input  logic            bus_req,
    input  logic            bus_we,
    input  logic [1:0]      bus_size,
    input  logic [AW-1:0]   bus_addr,
    output logic            dec_err,
    output logic            rd_en,
    output rd_sel_e         rd_sel,
    output logic [CW-1:0]   cpu_sel,
    output logic [NCPU-1:0] mask_we
);
    logic [IW-1:0] idx;
    logic          is_req, is_mask, is_route;
    int            mask_off, route_off;

    always_comb begin
        idx       = bus_addr[AW-1:IDX_LSB];
        mask_off  = int'(idx) - MASK_BASE;
        route_off = int'(idx) - ROUTE_BASE;
        is_req    = (int'(idx) == REQ_IDX);
        is_mask   = (mask_off >= 0) && (mask_off < NCPU);
        is_route  = (route_off >= 0) && (route_off < NCPU);

        dec_err = 1'b0;
        rd_en   = 1'b0;
        rd_sel  = SEL_NONE;
        cpu_sel = '0;
        mask_we = '0;

        if (is_mask) begin
            cpu_sel = CW'(mask_off);
        end else if (is_route) begin
            cpu_sel = CW'(route_off);
        end

        if (bus_req) begin
            if (bus_size != SZ_64) begin
                dec_err = 1'b1;
            end else if (bus_we) begin
                if (is_mask) begin
                    mask_we[mask_off] = 1'b1;
                end else begin
                    dec_err = 1'b1;
                end
            end else begin
                if (is_req) begin
                    rd_en  = 1'b1;
                    rd_sel = SEL_REQ;
                end else if (is_mask) begin
                    rd_en  = 1'b1;
                    rd_sel = SEL_MASK;
                end else if (is_route) begin
                    rd_en  = 1'b1;
                    rd_sel = SEL_ROUTE;
                end else begin
                    dec_err = 1'b1;
                end
            end
        end
    end

    always_comb begin
        a_r8_err_excludes_action: assert (!(dec_err && (rd_en || (|mask_we))));
        a_r9_one_mask_target: assert ($onehot0(mask_we));
    end
endmodule

// File: rtl/irq_route_lane.sv
module irq_route_lane #(
    parameter int NLINES = 64,
    parameter int DW     = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_we,
    input  logic [DW-1:0]     wdata,
    input  logic [NLINES-1:0] req_d_i,
    input  logic [NLINES-1:0] req_q_i,
    output logic [NLINES-1:0] mask_o,
    output logic [NLINES-1:0] routed_o,
    output logic [NLINES-1:0] post_o,
    output logic [NLINES-1:0] clr_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [NLINES-1:0] mask;
        logic [NLINES-1:0] routed;
        logic [NLINES-1:0] post;
        logic [NLINES-1:0] clr;
        logic              irq;
    } lane_state_t;

    lane_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mask_we) begin
            st_d.mask = wdata[NLINES-1:0];
        end
        st_d.routed = st_d.mask & req_d_i;
        st_d.post   = st_d.routed & ~st_q.routed;
        st_d.clr    = st_q.routed & ~st_d.routed;
        st_d.irq    = |st_d.routed;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o   = st_q.mask;
    assign routed_o = st_q.routed;
    assign post_o   = st_q.post;
    assign clr_o    = st_q.clr;
    assign irq_o    = st_q.irq;

    a_r3_routed_is_and: assert property (@(posedge clk) disable iff (!rst_n)
        routed_o == (mask_o & req_q_i));

    a_r4_post_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ((post_o & ~routed_o) == '0) && ((post_o & $past(routed_o)) == '0));

    a_r5_clear_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_o & routed_o) == '0) && ((clr_o & ~$past(routed_o)) == '0));

    a_r6_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|routed_o));

    a_r10_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask_o));
endmodule

// File: rtl/dev_irq_router.sv
module dev_irq_router
    import irq_router_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int NLINES = 64,
    parameter int DW     = 64,
    parameter int AW     = 12,
    localparam int LW    = $clog2(NLINES),
    localparam int CW    = $clog2(MAX_CPU)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   src_valid,
    input  logic                   src_set,
    input  logic [LW-1:0]          src_line,
    input  logic                   bus_req,
    input  logic                   bus_we,
    input  logic [1:0]             bus_size,
    input  logic [AW-1:0]          bus_addr,
    input  logic [DW-1:0]          bus_wdata,
    output logic [DW-1:0]          bus_rdata,
    output logic                   bus_rvalid,
    output logic                   bus_err,
    output logic [NCPU-1:0]        irq_out,
    output logic [NCPU*NLINES-1:0] post_evt,
    output logic [NCPU*NLINES-1:0] clr_evt
);
    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          rvalid;
        logic          err;
    } port_state_t;

    logic [NLINES-1:0] req_d, req_q;
    logic [NLINES-1:0] lane_mask   [NCPU];
    logic [NLINES-1:0] lane_routed [NCPU];
    logic [NLINES-1:0] lane_post   [NCPU];
    logic [NLINES-1:0] lane_clr    [NCPU];

    logic            dec_err, rd_en;
    rd_sel_e         rd_sel;
    logic [CW-1:0]   cpu_sel;
    logic [NCPU-1:0] mask_we;

    port_state_t ps_d, ps_q;

    irq_reg_decode #(.NCPU(NCPU), .AW(AW)) u_decode (
        .bus_req  (bus_req),
        .bus_we   (bus_we),
        .bus_size (bus_size),
        .bus_addr (bus_addr),
        .dec_err  (dec_err),
        .rd_en    (rd_en),
        .rd_sel   (rd_sel),
        .cpu_sel  (cpu_sel),
        .mask_we  (mask_we)
    );

    irq_request_reg #(.NLINES(NLINES)) u_request (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_valid (src_valid),
        .src_set   (src_set),
        .src_line  (src_line),
        .req_d_o   (req_d),
        .req_q_o   (req_q)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_lane
        irq_route_lane #(.NLINES(NLINES), .DW(DW)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .mask_we  (mask_we[c]),
            .wdata    (bus_wdata),
            .req_d_i  (req_d),
            .req_q_i  (req_q),
            .mask_o   (lane_mask[c]),
            .routed_o (lane_routed[c]),
            .post_o   (lane_post[c]),
            .clr_o    (lane_clr[c]),
            .irq_o    (irq_out[c])
        );
        assign post_evt[c*NLINES +: NLINES] = lane_post[c];
        assign clr_evt[c*NLINES +: NLINES]  = lane_clr[c];
    end

    always_comb begin
        ps_d        = '0;
        ps_d.err    = dec_err;
        ps_d.rvalid = rd_en;
        if (rd_en) begin
            unique case (rd_sel)
                SEL_REQ:   ps_d.rdata = DW'(req_q);
                SEL_MASK:  ps_d.rdata = DW'(lane_mask[cpu_sel]);
                SEL_ROUTE: ps_d.rdata = DW'(lane_routed[cpu_sel]);
                default:   ps_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end

    assign bus_rdata  = ps_q.rdata;
    assign bus_rvalid = ps_q.rvalid;
    assign bus_err    = ps_q.err;

    a_r8_narrow_err: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_size != SZ_64) |=> (bus_err && !bus_rvalid));

    a_r9_ro_write_err: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_size == SZ_64 &&
         bus_addr[AW-1:IDX_LSB] == (AW-IDX_LSB)'(REQ_IDX)) |=> bus_err);

    a_r7_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_size == SZ_64 &&
         bus_addr[AW-1:IDX_LSB] == (AW-IDX_LSB)'(REQ_IDX))
        |=> (bus_rvalid && bus_rdata == DW'($past(req_q))));

    a_r1_idle_port: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> (!bus_rvalid && !bus_err));
endmodule

// File: tb/dev_irq_router_tb_top.sv
module dev_irq_router_tb_top;
    localparam int NCPU = 4;
    localparam int NL   = 64;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            src_valid, src_set;
    logic [5:0]      src_line;
    logic            bus_req, bus_we;
    logic [1:0]      bus_size;
    logic [11:0]     bus_addr;
    logic [63:0]     bus_wdata;
    logic [63:0]     bus_rdata;
    logic            bus_rvalid, bus_err;
    logic [NCPU-1:0] irq_out;
    logic [NCPU*NL-1:0] post_evt, clr_evt;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    logic [63:0] mask_m [NCPU];
    logic [63:0] req_m;

    always #5 clk = ~clk;

    dev_irq_router dut_i (
        .clk(clk), .rst_n(rst_n),
        .src_valid(src_valid), .src_set(src_set), .src_line(src_line),
        .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .bus_err(bus_err),
        .irq_out(irq_out), .post_evt(post_evt), .clr_evt(clr_evt)
    );

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        src_valid = 1'b0; src_set = 1'b0; src_line = '0;
        bus_req = 1'b0; bus_we = 1'b0; bus_size = 2'b11;
        bus_addr = '0; bus_wdata = '0;
    endtask

    // One cycle of stimulus; model update and all output checks.
    task automatic op(input string tag,
                      input logic sv, input logic ss, input logic [5:0] ln,
                      input logic br, input logic bw, input logic [1:0] bs,
                      input logic [11:0] ba, input logic [63:0] bd);
        logic [63:0] old_r [NCPU];
        logic [63:0] new_r [NCPU];
        logic [NCPU*NL-1:0] exp_post, exp_clr;
        logic [NCPU-1:0] exp_irq;
        logic [63:0] exp_rd;
        logic exp_err, exp_rv;
        int idx;
        idx = int'(ba[11:6]);
        for (int c = 0; c < NCPU; c++) old_r[c] = mask_m[c] & req_m;
        exp_err = 1'b0; exp_rv = 1'b0; exp_rd = '0;
        if (br) begin
            if (bs != 2'b11) exp_err = 1'b1;
            else if (bw) begin
                if (idx >= 4 && idx < 8) mask_m[idx-4] = bd;
                else exp_err = 1'b1;
            end else begin
                exp_rv = 1'b1;
                if (idx == 0) exp_rd = req_m;
                else if (idx >= 4 && idx < 8) exp_rd = mask_m[idx-4];
                else if (idx >= 8 && idx < 12) exp_rd = old_r[idx-8];
                else begin exp_rv = 1'b0; exp_err = 1'b1; end
            end
        end
        if (sv) req_m[ln] = ss;
        for (int c = 0; c < NCPU; c++) begin
            new_r[c] = mask_m[c] & req_m;
            exp_post[c*NL +: NL] = new_r[c] & ~old_r[c];
            exp_clr[c*NL +: NL]  = old_r[c] & ~new_r[c];
            exp_irq[c] = |new_r[c];
        end
        src_valid = sv; src_set = ss; src_line = ln;
        bus_req = br; bus_we = bw; bus_size = bs; bus_addr = ba; bus_wdata = bd;
        @(negedge clk);
        idle();
        chk({tag, " post_evt"}, 256'(post_evt), 256'(exp_post));
        chk({tag, " clr_evt"},  256'(clr_evt),  256'(exp_clr));
        chk({tag, " irq_out"},  256'(irq_out),  256'(exp_irq));
        chk({tag, " bus_err"},  256'(bus_err),  256'(exp_err));
        chk({tag, " rvalid"},   256'(bus_rvalid), 256'(exp_rv));
        if (exp_rv) chk({tag, " rdata"}, 256'(bus_rdata), 256'(exp_rd));
    endtask

    task automatic rd(input string tag, input int idx);
        op(tag, 1'b0, 1'b0, 6'd0, 1'b1, 1'b0, 2'b11, 12'(idx << 6), 64'd0);
    endtask

    task automatic wr_mask(input string tag, input int c, input logic [63:0] v);
        op(tag, 1'b0, 1'b0, 6'd0, 1'b1, 1'b1, 2'b11, 12'((4 + c) << 6), v);
    endtask

    task automatic src(input string tag, input logic ss, input logic [5:0] ln);
        op(tag, 1'b1, ss, ln, 1'b0, 1'b0, 2'b11, 12'd0, 64'd0);
    endtask

    task automatic dump_all(input string tag);
        rd(tag, 0);
        for (int c = 0; c < NCPU; c++) begin
            rd(tag, 4 + c);
            rd(tag, 8 + c);
        end
    endtask

    task automatic t_reset();
        dump_all("R1 reset");
        chk("R1 reset irq", 256'(irq_out), 256'(0));
    endtask

    task automatic t_mask_no_req();
        wr_mask("R3 mask without request", 0, 64'h0000_0000_0000_00F0);
        rd("R3 routed stays zero", 8);
    endtask

    task automatic t_source_post();
        src("R4 R6 source post line 5", 1'b1, 6'd5);
        rd("R2 request bit 5", 0);
        src("R4 repeat post no event", 1'b1, 6'd5);
    endtask

    task automatic t_source_clear();
        src("R5 source clear line 5", 1'b0, 6'd5);
        src("R2 spurious clear", 1'b0, 6'd5);
        rd("R2 request after spurious", 0);
    endtask

    task automatic t_mask_drop();
        wr_mask("R4 mask1 bit63", 1, 64'h8000_0000_0000_0001);
        src("R4 post line 63 cpu1", 1'b1, 6'd63);
        wr_mask("R5 mask1 drop bit63", 1, 64'h0000_0000_0000_0001);
        wr_mask("R4 mask1 restore bit63", 1, 64'h8000_0000_0000_0000);
    endtask

    task automatic t_multi_cpu();
        wr_mask("R3 mask2", 2, 64'h0000_0001_0000_0000);
        wr_mask("R3 mask3", 3, 64'hFFFF_FFFF_FFFF_FFFF);
        src("R4 line 32 to cpu2 cpu3", 1'b1, 6'd32);
        src("R5 line 32 clear both", 1'b0, 6'd32);
    endtask

    task automatic t_errors();
        op("R8 narrow mask write", 1'b0, 1'b0, 6'd0, 1'b1, 1'b1, 2'b10, 12'(4 << 6), 64'hDEAD);
        op("R8 narrow read", 1'b0, 1'b0, 6'd0, 1'b1, 1'b0, 2'b00, 12'(0), 64'd0);
        op("R9 request write", 1'b0, 1'b0, 6'd0, 1'b1, 1'b1, 2'b11, 12'(0), '1);
        op("R9 routed write", 1'b0, 1'b0, 6'd0, 1'b1, 1'b1, 2'b11, 12'(9 << 6), '1);
        op("R9 unmapped read", 1'b0, 1'b0, 6'd0, 1'b1, 1'b0, 2'b11, 12'(2 << 6), 64'd0);
        op("R9 unmapped write", 1'b0, 1'b0, 6'd0, 1'b1, 1'b1, 2'b11, 12'(12 << 6), '1);
        dump_all("R9 state unchanged");
    endtask

    task automatic t_same_cycle();
        op("R10 mask0 write with line 7", 1'b1, 1'b1, 6'd7, 1'b1, 1'b1, 2'b11,
           12'(4 << 6), 64'h0000_0000_0000_0080);
        op("R10 mask0 drop with line 63 set", 1'b1, 1'b1, 6'd63, 1'b1, 1'b1, 2'b11,
           12'(4 << 6), 64'h8000_0000_0000_0000);
        dump_all("R10 combined state");
    endtask

    task automatic t_offset_ignore();
        op("R7 low offset bits ignored", 1'b0, 1'b0, 6'd0, 1'b1, 1'b0, 2'b11,
           12'((5 << 6) | 6'h38), 64'd0);
        op("R7 low offset on write", 1'b0, 1'b0, 6'd0, 1'b1, 1'b1, 2'b11,
           12'((6 << 6) | 6'h3F), 64'h0000_0000_0000_0080);
        rd("R7 readback mask2", 6);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 1'b0;
        req_m = '0;
        for (int c = 0; c < NCPU; c++) mask_m[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mask_no_req();
        t_source_post();
        t_source_clear();
        t_mask_drop();
        t_multi_cpu();
        t_errors();
        t_same_cycle();
        t_offset_ignore();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule